// File: doc/BRIEF.md
# Set-Associative Hash Tag Table

This block keeps track of which slots of an external record store are occupied, keyed by a hash that some other unit has already computed from a request key. The upper hash bits pick a row, and the remaining low bits are kept in that row as a short tag. Each row is a small group of ways. The address of a record slot follows directly from the row number and the way number, so the table holds no pointers. Only the truncated tag is stored, never the key, so a tag hit is only a candidate: a later stage has to compare the full key held in the record slot.

Three operations are accepted, one per cycle. An insert claims a way for a tag. A lookup reports whether a valid way of the row holds the tag. A delete invalidates the matching way. Replacement uses one recently-used bit per way. Every result comes back exactly one cycle after the request, together with the way and the byte address of the record slot. The tag width, the number of ways and the hash width are parameters. A narrow-tag arrangement, with fewer tag bits, more rows and fewer ways, is a choice of parameter values. The defaults are 16 hash bits, a 9-bit tag, 128 rows, 8 ways and 512-byte record slots.

Top module: `hashtag_table`

## Requirements
- R1: After reset every way of every row is invalid, so any lookup misses, and rsp_valid is low while reset is held.
- R2: req_ready is always high. Each cycle with req_valid high produces exactly one response with rsp_valid high on the following cycle, and cycles without a request produce no response.
- R3: The row is req_hash[HASH_W-1:TAG_W] and the tag is req_hash[TAG_W-1:0]. The opcode req_op is 0 for lookup, 1 for insert and 2 for delete. Code 3 behaves exactly as a lookup.
- R4: A lookup returns rsp_hit=1 and the matching way when a valid way of the row holds the tag. Otherwise it returns rsp_hit=0 and way 0, and it changes no state.
- R5: An insert whose tag is not present takes the lowest-numbered invalid way of the row, marks it valid, stores the tag and returns rsp_hit=0 with that way.
- R6: An insert whose tag is already valid in the row reuses that way, so it never creates a second copy, and returns rsp_hit=1.
- R7: An insert of a new tag into a full row evicts the lowest-numbered way whose recently-used bit is clear. The evicted tag then misses.
- R8: A lookup hit or an insert sets the recently-used bit of its way. If that would set every bit of the row, all other bits of the row are cleared instead.
- R9: A delete whose tag matches a valid way clears its valid bit and its recently-used bit and returns rsp_hit=1 with that way. A delete with no match changes nothing and returns rsp_hit=0.
- R10: rsp_addr is the slot number (row × WAYS + way) shifted left by REC_SHIFT. For a miss the slot is the one of way 0.
- R11: Rows are independent. The same tag under a different row index neither hits nor disturbs the other row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_ready | output | 1 | Always high; a request is taken every cycle |
| req_op | input | 2 | 0 lookup, 1 insert, 2 delete, 3 lookup |
| req_hash | input | HASH_W | Key hash: row bits on top, tag bits below |
| rsp_valid | output | 1 | Response present, one cycle after its request |
| rsp_hit | output | 1 | Tag matched (lookup/delete) or way reused (insert) |
| rsp_way | output | WAY_W | Way chosen or matched |
| rsp_addr | output | IDX_W+WAY_W+REC_SHIFT | Byte address of the record slot |

## Verification
Table state can only be seen through later responses. A stale valid bit shows up as a hit on the next lookup of that row and tag. A wrong recently-used bit goes unseen until a full row has to choose a victim, where it shows as a wrong rsp_way and wrong rsp_addr one cycle after that insert. The bench therefore fills rows, touches chosen ways, deletes and refills them, and follows up with lookups on both the evicted tags and the surviving tags. A reference model built from the requirements predicts every response. A long mixed sequence confined to two rows drives the eviction order through many wrap-arounds of the recently-used bits.

// File: rtl/hashtag_pkg.sv
package hashtag_pkg;

    typedef enum logic [1:0] {
        OP_LOOKUP = 2'b00,
        OP_INSERT = 2'b01,
        OP_DELETE = 2'b10,
        OP_PROBE  = 2'b11
    } ht_op_e;

endpackage

// File: rtl/hashtag_row_match.sv
module hashtag_row_match #(
    parameter int TAG_W = 9,
    parameter int WAYS  = 8,
    parameter int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [WAYS*TAG_W-1:0]    row_tags,
    input  logic [WAYS-1:0]          row_valid,
    input  logic [WAYS-1:0]          row_mru,
    input  logic [TAG_W-1:0]         tag,
    output logic                     hit,
    output logic [WAY_W-1:0]         hit_way,
    output logic                     has_free,
    output logic [WAY_W-1:0]         free_way,
    output logic [WAY_W-1:0]         victim_way
);

    logic [WAYS-1:0] hit_vec;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = row_valid[w] && (row_tags[w*TAG_W +: TAG_W] == tag);
    end

    // Lowest-numbered way wins in each of the three searches.
    always_comb begin
        hit_way    = '0;
        free_way   = '0;
        victim_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w])    hit_way    = WAY_W'(w);
            if (!row_valid[w]) free_way   = WAY_W'(w);
            if (!row_mru[w])   victim_way = WAY_W'(w);
        end
    end

    assign hit      = |hit_vec;
    assign has_free = ~&row_valid;

    // R6: insert reuses a matching way, so at most one way can match.
    a_r6_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

endmodule

// File: rtl/hashtag_mru_next.sv
module hashtag_mru_next #(
    parameter int WAYS  = 8,
    parameter int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WAYS-1:0]  mru_cur,
    input  logic             touch,
    input  logic             drop,
    input  logic [WAY_W-1:0] way,
    output logic [WAYS-1:0]  mru_nxt
);

    logic [WAYS-1:0] sel_mask;

    always_comb begin
        sel_mask = '0;
        sel_mask[way] = 1'b1;
        mru_nxt = mru_cur;
        if (drop) begin
            mru_nxt = mru_cur & ~sel_mask;
        end else if (touch) begin
            mru_nxt = mru_cur | sel_mask;
            if (&mru_nxt) mru_nxt = sel_mask;
        end
    end

    // R8: a touched row never ends with every recently-used bit set.
    a_r8_not_saturated: assert property (@(posedge clk) disable iff (!rst_n)
        (touch && (WAYS > 1)) |-> !(&mru_nxt));

endmodule

// File: rtl/hashtag_table.sv
module hashtag_table
    import hashtag_pkg::*;
#(
    parameter int HASH_W    = 16,
    parameter int TAG_W     = 9,
    parameter int WAYS      = 8,
    parameter int REC_SHIFT = 9,
    localparam int IDX_W    = HASH_W - TAG_W,
    localparam int ROWS     = 1 << IDX_W,
    localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int ADDR_W   = IDX_W + WAY_W + REC_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [HASH_W-1:0] req_hash,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WAY_W-1:0]  rsp_way,
    output logic [ADDR_W-1:0] rsp_addr
);

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic [WAY_W-1:0]  way;
        logic [ADDR_W-1:0] addr;
    } rsp_t;

    typedef struct packed {
        logic              wr;
        logic [WAYS-1:0]   valid;
        logic [WAYS-1:0]   mru;
        logic              tag_wr;
    } upd_t;

    logic [WAYS*TAG_W-1:0] tag_q   [ROWS];
    logic [WAYS-1:0]       valid_q [ROWS];
    logic [WAYS-1:0]       mru_q   [ROWS];

    rsp_t rsp_d, rsp_q;
    upd_t upd_d;

    logic [IDX_W-1:0] row_idx;
    logic [TAG_W-1:0] row_tag;
    ht_op_e           op;

    assign row_idx = req_hash[HASH_W-1:TAG_W];
    assign row_tag = req_hash[TAG_W-1:0];
    assign op      = ht_op_e'(req_op);

    logic             m_hit, m_has_free;
    logic [WAY_W-1:0] m_hit_way, m_free_way, m_victim_way;

    hashtag_row_match #(.TAG_W(TAG_W), .WAYS(WAYS), .WAY_W(WAY_W)) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .row_tags   (tag_q[row_idx]),
        .row_valid  (valid_q[row_idx]),
        .row_mru    (mru_q[row_idx]),
        .tag        (row_tag),
        .hit        (m_hit),
        .hit_way    (m_hit_way),
        .has_free   (m_has_free),
        .free_way   (m_free_way),
        .victim_way (m_victim_way)
    );

    // Decide which way the operation acts on and how it touches the row.
    logic             sel_hit;
    logic [WAY_W-1:0] sel_way;
    logic             touch, drop, claim;

    always_comb begin
        sel_hit = 1'b0;
        sel_way = '0;
        touch   = 1'b0;
        drop    = 1'b0;
        claim   = 1'b0;
        unique case (op)
            OP_INSERT: begin
                claim = 1'b1;
                touch = 1'b1;
                if (m_hit) begin
                    sel_hit = 1'b1;
                    sel_way = m_hit_way;
                end else if (m_has_free) begin
                    sel_way = m_free_way;
                end else begin
                    sel_way = m_victim_way;
                end
            end
            OP_DELETE: begin
                if (m_hit) begin
                    sel_hit = 1'b1;
                    sel_way = m_hit_way;
                    drop    = 1'b1;
                end
            end
            OP_LOOKUP, OP_PROBE: begin
                if (m_hit) begin
                    sel_hit = 1'b1;
                    sel_way = m_hit_way;
                    touch   = 1'b1;
                end
            end
            default: ;
        endcase
    end

    logic [WAYS-1:0] mru_row_nxt;

    hashtag_mru_next #(.WAYS(WAYS), .WAY_W(WAY_W)) u_mru (
        .clk     (clk),
        .rst_n   (rst_n),
        .mru_cur (mru_q[row_idx]),
        .touch   (touch),
        .drop    (drop),
        .way     (sel_way),
        .mru_nxt (mru_row_nxt)
    );

    // Next-state values for the response register and the indexed row.
    always_comb begin
        logic [WAYS-1:0] way_mask;
        way_mask = '0;
        way_mask[sel_way] = 1'b1;

        rsp_d.valid = req_valid;
        rsp_d.hit   = sel_hit;
        rsp_d.way   = sel_way;
        rsp_d.addr  = {row_idx, sel_way, {REC_SHIFT{1'b0}}};

        upd_d.wr     = req_valid && (touch || drop);
        upd_d.tag_wr = req_valid && claim;
        upd_d.mru    = mru_row_nxt;
        upd_d.valid  = valid_q[row_idx];
        if (claim) upd_d.valid = valid_q[row_idx] | way_mask;
        if (drop)  upd_d.valid = valid_q[row_idx] & ~way_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
            for (int r = 0; r < ROWS; r++) begin
                valid_q[r] <= '0;
                mru_q[r]   <= '0;
            end
        end else begin
            rsp_q <= rsp_d;
            if (upd_d.wr) begin
                valid_q[row_idx] <= upd_d.valid;
                mru_q[row_idx]   <= upd_d.mru;
            end
            if (upd_d.tag_wr) begin
                tag_q[row_idx][int'(sel_way)*TAG_W +: TAG_W] <= row_tag;
            end
        end
    end

    assign req_ready = 1'b1;
    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_way   = rsp_q.way;
    assign rsp_addr  = rsp_q.addr;

    // R2: one response per request, one cycle later, none otherwise.
    a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R5: the way an insert chose is valid afterwards.
    a_r5_insert_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op == OP_INSERT) |=> valid_q[$past(row_idx)][$past(sel_way)]);

    // R9: a matching delete leaves its way invalid.
    a_r9_delete_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op == OP_DELETE && m_hit) |=> !valid_q[$past(row_idx)][$past(sel_way)]);

    // R4: a lookup miss answers on way 0 without a hit.
    a_r4_miss_way_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (op == OP_LOOKUP || op == OP_PROBE) && !m_hit) |=> (!rsp_hit && rsp_way == '0));

endmodule

// File: tb/hashtag_table_tb.sv
module hashtag_table_tb;

    localparam int HASH_W    = 16;
    localparam int TAG_W     = 9;
    localparam int WAYS      = 8;
    localparam int REC_SHIFT = 9;
    localparam int IDX_W     = HASH_W - TAG_W;
    localparam int ROWS      = 1 << IDX_W;
    localparam int WAY_W     = 3;
    localparam int ADDR_W    = IDX_W + WAY_W + REC_SHIFT;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [1:0]        req_op = 2'd0;
    logic [HASH_W-1:0] req_hash = '0;
    logic              rsp_valid;
    logic              rsp_hit;
    logic [WAY_W-1:0]  rsp_way;
    logic [ADDR_W-1:0] rsp_addr;

    always #5 clk = ~clk;

    hashtag_table #(.HASH_W(HASH_W), .TAG_W(TAG_W), .WAYS(WAYS), .REC_SHIFT(REC_SHIFT)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_op    (req_op),
        .req_hash  (req_hash),
        .rsp_valid (rsp_valid),
        .rsp_hit   (rsp_hit),
        .rsp_way   (rsp_way),
        .rsp_addr  (rsp_addr)
    );

    typedef struct {
        bit    hit;
        int    way;
        int    addr;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad   = 0;
    bit   done  = 1'b0;

    bit m_valid [ROWS][WAYS];
    bit m_mru   [ROWS][WAYS];
    int m_tag   [ROWS][WAYS];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic void touch_way(int row, int w);
        bit all_set;
        m_mru[row][w] = 1'b1;
        all_set = 1'b1;
        for (int i = 0; i < WAYS; i++) if (!m_mru[row][i]) all_set = 1'b0;
        if (all_set) begin
            for (int i = 0; i < WAYS; i++) m_mru[row][i] = 1'b0;
            m_mru[row][w] = 1'b1;
        end
    endfunction

    // Driver: predicts the response from the requirement model and pushes it.
    task automatic send(input int op, input int row, input int tag, input string req);
        exp_t e;
        int   hw;
        hw = -1;
        for (int i = 0; i < WAYS; i++)
            if (hw < 0 && m_valid[row][i] && m_tag[row][i] == tag) hw = i;
        e.hit = 1'b0;
        e.way = 0;
        e.req = req;
        if (op == 1) begin
            if (hw >= 0) begin
                e.hit = 1'b1;
                e.way = hw;
            end else begin
                int fw;
                fw = -1;
                for (int i = 0; i < WAYS; i++) if (fw < 0 && !m_valid[row][i]) fw = i;
                if (fw < 0)
                    for (int i = 0; i < WAYS; i++) if (fw < 0 && !m_mru[row][i]) fw = i;
                if (fw < 0) fw = 0;
                e.way = fw;
            end
            m_valid[row][e.way] = 1'b1;
            m_tag[row][e.way]   = tag;
            touch_way(row, e.way);
        end else if (op == 2) begin
            if (hw >= 0) begin
                e.hit = 1'b1;
                e.way = hw;
                m_valid[row][hw] = 1'b0;
                m_mru[row][hw]   = 1'b0;
            end
        end else begin
            if (hw >= 0) begin
                e.hit = 1'b1;
                e.way = hw;
                touch_way(row, hw);
            end
        end
        e.addr = ((row * WAYS) + e.way) << REC_SHIFT;
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = 2'(op);
        req_hash  = HASH_W'((row << TAG_W) | tag);
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    // Monitor: pops the oldest expectation whenever a response appears.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", "response without request", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(rsp_hit == e.hit, e.req, "rsp_hit", rsp_hit, e.hit);
                check(int'(rsp_way) == e.way, e.req, "rsp_way", rsp_way, e.way);
                check(int'(rsp_addr) == e.addr, e.req, "rsp_addr", rsp_addr, e.addr);
            end
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R2 watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < ROWS; r++)
            for (int w = 0; w < WAYS; w++) begin
                m_valid[r][w] = 1'b0;
                m_mru[r][w]   = 1'b0;
                m_tag[r][w]   = 0;
            end

        repeat (3) @(negedge clk);
        check(rsp_valid == 1'b0, "R1", "rsp_valid in reset", rsp_valid, 0);
        check(req_ready == 1'b1, "R2", "req_ready", req_ready, 1);
        rst_n = 1'b1;

        // R1: empty table misses everywhere
        send(0, 5, 'h11, "R1");
        send(0, 0, 0, "R1");
        send(0, 127, 511, "R1");
        // R5 / R4 / R10 / R3: first insert and its lookups
        send(1, 5, 'h11, "R5");
        send(0, 5, 'h11, "R4");
        send(3, 5, 'h11, "R3");
        send(0, 5, 'h12, "R10");
        // R6: repeated insert reuses the way
        send(1, 5, 'h11, "R6");
        // R5 / R8: fill the row; the last insert wraps the recently-used bits
        for (int t = 0; t < 7; t++) send(1, 5, 'h20 + t, "R5");
        // R7: victim is the lowest way whose bit is clear
        send(1, 5, 'h30, "R7");
        send(0, 5, 'h11, "R7");
        send(0, 5, 'h21, "R8");
        send(1, 5, 'h31, "R8");
        // R9: delete, repeated delete, refill of the freed way
        send(2, 5, 'h23, "R9");
        send(0, 5, 'h23, "R9");
        send(2, 5, 'h23, "R9");
        send(1, 5, 'h40, "R9");
        // R11: same tag in another row
        send(0, 6, 'h20, "R11");
        send(1, 6, 'h20, "R11");
        send(0, 5, 'h20, "R11");
        send(0, 6, 'h20, "R11");
        idle(3);
        check(rsp_valid == 1'b0, "R2", "rsp_valid when idle", rsp_valid, 0);
        check(exp_q.size() == 0, "R2", "outstanding responses", exp_q.size(), 0);

        // R8: long mixed sequence in two rows against the model
        for (int i = 0; i < 600; i++) begin
            int op, row, tag;
            op  = int'($urandom_range(3, 0));
            if ($urandom_range(2, 0) != 0) op = (op == 2) ? 2 : (op & 1);
            row = ($urandom_range(1, 0) == 0) ? 9 : 77;
            tag = int'($urandom_range(11, 0)) * 37;
            send(op, row, tag, "R8");
        end
        idle(3);
        check(exp_q.size() == 0, "R2", "outstanding after mix", exp_q.size(), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule